// File: doc/BRIEF.md
# TDM Transmit Slot Gating

This block walks the time slots of a serial frame and decides, for every slot, whether the transmitter takes part in that channel and, if it does, whether the data for that slot is masked. A masked slot is driven in high impedance. A frame sync starts a frame. Each slot strobe then consumes the next channel number. One cycle after each accepted strobe, the block emits a result carrying the channel number, an enabled flag and a masked flag.

The selection rule comes from a 2-bit mode and from a set of per-channel select bits. The block holds 128 transmit select bits and 128 receive select bits. A width control chooses between two layouts. In the first, all 128 channels are individually selectable. In the second, only two 16-channel blocks are selectable, and a pair pointer places them. The mode, the width, both pointers and both bit banks are captured at frame sync, so software may rewrite them at any time without disturbing the frame in progress.

Slot timing is set by the serial line, so the result stream cannot be held back. `res_valid` is a one-cycle qualifier with no ready. A downstream shifter must take each result in the cycle it appears.

Top module: `tdm_tx_chsel`

## Requirements
- R1: With mode 2'b00, every reported channel has enabled=1 and masked=0, whatever the select bits hold.
- R2: With mode 2'b01, a channel is enabled only when its transmit select bit is set. It is never masked.
- R3: With mode 2'b10, every channel is enabled. A channel is masked when its transmit select bit is clear.
- R4: With mode 2'b11, a channel is enabled only when its receive select bit is set. An enabled channel is masked unless its transmit select bit is also set. Both lookups use the receive pair pointer.
- R5: With wide_sel=1, the select bit for channel c is bit c of the bank.
- R6: With wide_sel=0 and pair pointer p, channels 32p..32p+15 use bank bits [15:0], and channels 32p+16..32p+31 use bank bits [31:16]. Bit k maps to the k-th channel of its block. All other channels count as not selected. Modes 2'b01 and 2'b10 use the transmit pair pointer.
- R7: A frame sync restarts the count at channel 0. Each later strobe reports the next channel one cycle after the strobe. Strobes after the 128th channel of a frame, and strobes before the first frame sync, give no result.
- R8: A strobe in the same cycle as a frame sync is reported as channel 0 of the new frame, under the configuration presented in that cycle.
- R9: The mode, width, pointers and bit banks are captured at frame sync. Changes made during a frame have no effect until the next frame sync.
- R10: A channel that is not enabled is always reported with masked=0.
- R11: After reset, res_valid is 0 until a strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | Frame start; captures the configuration |
| slot_strobe | input | 1 | One pulse per channel slot |
| sel_mode | input | 2 | Selection mode (00 off, 01 enable-select, 10 mask-select, 11 symmetric) |
| wide_sel | input | 1 | 1: 128 selectable channels, 0: two 16-channel blocks |
| tx_pair | input | 2 | Block pair pointer for modes 01 and 10 |
| rx_pair | input | 2 | Block pair pointer for mode 11 |
| tx_en_bits | input | 128 | Transmit select bits |
| rx_en_bits | input | 128 | Receive select bits |
| res_valid | output | 1 | Result qualifier, one cycle per accepted slot |
| res_chan | output | 7 | Channel number of the result |
| res_enabled | output | 1 | Transmitter takes part in the slot |
| res_masked | output | 1 | Slot data is driven in high impedance |

## Verification
A frame sync and a slot strobe can arrive in the same cycle. When they do, the counter restart, the configuration capture and the slot decision all collide. The bench provokes this by raising both pins together, after a frame run under a different mode and different bits. It expects channel 0, decided by the freshly presented settings. A second collision is a configuration write during a frame. The bench rewrites the mode and the banks part-way through a frame and keeps scoring the remaining slots against the settings captured at the frame start.

// File: rtl/tdm_chsel_pkg.sv
package tdm_chsel_pkg;
  typedef enum logic [1:0] {
    SEL_OFF    = 2'b00,
    SEL_TXONLY = 2'b01,
    SEL_MASKED = 2'b10,
    SEL_SYMM   = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int NCH = 128,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          slot_strobe,
  output logic          slot_go,
  output logic [CW-1:0] slot_chan
);
  logic [CW-1:0] cnt;
  logic          idle;

  assign slot_go   = slot_strobe && (frame_sync || !idle);
  assign slot_chan = frame_sync ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      idle <= 1'b1;
    end else if (frame_sync) begin
      idle <= 1'b0;
      cnt  <= slot_strobe ? CW'(1) : '0;
    end else if (slot_strobe && !idle) begin
      if (cnt == CW'(NCH-1)) idle <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  p_chan_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_strobe && !frame_sync && !idle && cnt != CW'(NCH-1) |=> cnt == $past(cnt) + 1'b1);

  p_sync_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && slot_strobe |=> cnt == CW'(1) && !idle);
endmodule

// File: rtl/tdm_cfg_latch.sv
module tdm_cfg_latch
  import tdm_chsel_pkg::*;
#(
  parameter int NCH = 128,
  parameter int PW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  sel_mode_e       mode_i,
  input  logic            wide_i,
  input  logic [PW-1:0]   txp_i,
  input  logic [PW-1:0]   rxp_i,
  input  logic [NCH-1:0]  tx_i,
  input  logic [NCH-1:0]  rx_i,
  output sel_mode_e       mode_o,
  output logic            wide_o,
  output logic [PW-1:0]   txp_o,
  output logic [PW-1:0]   rxp_o,
  output logic [NCH-1:0]  tx_o,
  output logic [NCH-1:0]  rx_o
);
  sel_mode_e      mode_q;
  logic           wide_q;
  logic [PW-1:0]  txp_q, rxp_q;
  logic [NCH-1:0] tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SEL_OFF;
      wide_q <= 1'b0;
      txp_q  <= '0;
      rxp_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (load) begin
      mode_q <= mode_i;
      wide_q <= wide_i;
      txp_q  <= txp_i;
      rxp_q  <= rxp_i;
      tx_q   <= tx_i;
      rx_q   <= rx_i;
    end
  end

  // the frame-start slot sees the settings presented with the sync
  assign mode_o = load ? mode_i : mode_q;
  assign wide_o = load ? wide_i : wide_q;
  assign txp_o  = load ? txp_i  : txp_q;
  assign rxp_o  = load ? rxp_i  : rxp_q;
  assign tx_o   = load ? tx_i   : tx_q;
  assign rx_o   = load ? rx_i   : rx_q;

  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q) && $stable(tx_q) && $stable(rx_q) && $stable(wide_q));
endmodule

// File: rtl/tdm_bit_lookup.sv
module tdm_bit_lookup #(
  parameter int NCH = 128,
  parameter int BLK = 16,
  localparam int CW = $clog2(NCH),
  localparam int BW = $clog2(BLK),
  localparam int PW = CW - BW - 1
) (
  input  logic [NCH-1:0] bits,
  input  logic [CW-1:0]  chan,
  input  logic           wide,
  input  logic [PW-1:0]  pair,
  output logic           hit
);
  logic [CW-BW-1:0] blk;
  logic [CW-1:0]    idx;

  always_comb begin
    blk = chan[CW-1:BW];
    idx = '0;
    hit = 1'b0;
    if (wide) begin
      hit = bits[chan];
    end else if (blk == {pair, 1'b0}) begin
      idx = {{(CW-BW){1'b0}}, chan[BW-1:0]};
      hit = bits[idx];
    end else if (blk == {pair, 1'b1}) begin
      idx = CW'(BLK) + {{(CW-BW){1'b0}}, chan[BW-1:0]};
      hit = bits[idx];
    end
  end
endmodule

// File: rtl/tdm_tx_chsel.sv
module tdm_tx_chsel
  import tdm_chsel_pkg::*;
#(
  parameter int NCH = 128,
  parameter int BLK = 16,
  localparam int CW = $clog2(NCH),
  localparam int PW = $clog2(NCH / BLK) - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_sync,
  input  logic           slot_strobe,
  input  logic [1:0]     sel_mode,
  input  logic           wide_sel,
  input  logic [PW-1:0]  tx_pair,
  input  logic [PW-1:0]  rx_pair,
  input  logic [NCH-1:0] tx_en_bits,
  input  logic [NCH-1:0] rx_en_bits,
  output logic           res_valid,
  output logic [CW-1:0]  res_chan,
  output logic           res_enabled,
  output logic           res_masked
);
  logic          slot_go;
  logic [CW-1:0] slot_chan;
  sel_mode_e     eff_mode;
  logic          eff_wide;
  logic [PW-1:0] eff_txp, eff_rxp, tx_lookup_pair;
  logic [NCH-1:0] eff_tx, eff_rx;
  logic          tx_hit, rx_hit, en_d, mask_d;

  tdm_slot_counter #(.NCH(NCH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_strobe(slot_strobe),
    .slot_go(slot_go), .slot_chan(slot_chan)
  );

  tdm_cfg_latch #(.NCH(NCH), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(frame_sync),
    .mode_i(sel_mode_e'(sel_mode)), .wide_i(wide_sel), .txp_i(tx_pair), .rxp_i(rx_pair),
    .tx_i(tx_en_bits), .rx_i(rx_en_bits),
    .mode_o(eff_mode), .wide_o(eff_wide), .txp_o(eff_txp), .rxp_o(eff_rxp),
    .tx_o(eff_tx), .rx_o(eff_rx)
  );

  // symmetric mode places the transmit bits with the receive pointer
  assign tx_lookup_pair = (eff_mode == SEL_SYMM) ? eff_rxp : eff_txp;

  tdm_bit_lookup #(.NCH(NCH), .BLK(BLK)) u_txl (
    .bits(eff_tx), .chan(slot_chan), .wide(eff_wide), .pair(tx_lookup_pair), .hit(tx_hit)
  );
  tdm_bit_lookup #(.NCH(NCH), .BLK(BLK)) u_rxl (
    .bits(eff_rx), .chan(slot_chan), .wide(eff_wide), .pair(eff_rxp), .hit(rx_hit)
  );

  always_comb begin
    unique case (eff_mode)
      SEL_OFF:    begin en_d = 1'b1;   mask_d = 1'b0;            end
      SEL_TXONLY: begin en_d = tx_hit; mask_d = 1'b0;            end
      SEL_MASKED: begin en_d = 1'b1;   mask_d = !tx_hit;         end
      default:    begin en_d = rx_hit; mask_d = rx_hit && !tx_hit; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_chan    <= '0;
      res_enabled <= 1'b0;
      res_masked  <= 1'b0;
    end else begin
      res_valid <= slot_go;
      if (slot_go) begin
        res_chan    <= slot_chan;
        res_enabled <= en_d;
        res_masked  <= mask_d;
      end
    end
  end

  p_disabled_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_enabled |-> !res_masked);

  p_no_strobe_no_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_strobe |=> !res_valid);

  p_mode_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go && eff_mode == SEL_OFF |=> res_enabled && !res_masked);

  p_sync_chan0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && slot_strobe |=> res_valid && res_chan == '0);
endmodule

// File: tb/sim_tdm_tx_chsel.sv
`timescale 1ns/1ps
module sim_tdm_tx_chsel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0, slot_strobe = 1'b0;
  logic [1:0] sel_mode = 2'b00;
  logic wide_sel = 1'b1;
  logic [1:0] tx_pair = '0, rx_pair = '0;
  logic [127:0] tx_en_bits = '0, rx_en_bits = '0;
  logic res_valid, res_enabled, res_masked;
  logic [6:0] res_chan;

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  string      req_q[$];

  // captured model configuration
  logic [1:0] m_mode; logic m_wide; int m_txp, m_rxp;
  logic [127:0] m_tx, m_rx;
  int m_cnt = 0;
  bit m_live = 0;

  always #4 clk = ~clk;

  tdm_tx_chsel u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_strobe(slot_strobe),
    .sel_mode(sel_mode), .wide_sel(wide_sel), .tx_pair(tx_pair), .rx_pair(rx_pair),
    .tx_en_bits(tx_en_bits), .rx_en_bits(rx_en_bits),
    .res_valid(res_valid), .res_chan(res_chan), .res_enabled(res_enabled), .res_masked(res_masked)
  );

  function automatic bit pick(logic [127:0] b, int ch, bit wide, int pair);
    int blk = ch / 16;
    if (wide) return b[ch];
    if (blk == 2 * pair) return b[ch % 16];
    if (blk == 2 * pair + 1) return b[16 + ch % 16];
    return 1'b0;
  endfunction

  function automatic logic [8:0] predict(int ch);
    bit e, m, t, r;
    case (m_mode)
      2'b00: begin e = 1; m = 0; end
      2'b01: begin t = pick(m_tx, ch, m_wide, m_txp); e = t; m = 0; end
      2'b10: begin t = pick(m_tx, ch, m_wide, m_txp); e = 1; m = !t; end
      default: begin
        r = pick(m_rx, ch, m_wide, m_rxp);
        t = pick(m_tx, ch, m_wide, m_rxp);
        e = r; m = r && !t;
      end
    endcase
    return {7'(ch), e, m};
  endfunction

  task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected result", 1'b0, {22'd0, res_chan, res_enabled, res_masked}, 32'h0);
      end else begin
        logic [8:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {res_chan, res_enabled, res_masked} == e,
              {23'd0, res_chan, res_enabled, res_masked}, {23'd0, e});
      end
    end
  end

  task automatic fsync(bit with_strobe, string req);
    @(negedge clk);
    frame_sync = 1'b1;
    slot_strobe = with_strobe;
    m_mode = sel_mode; m_wide = wide_sel; m_txp = tx_pair; m_rxp = rx_pair;
    m_tx = tx_en_bits; m_rx = rx_en_bits;
    m_live = 1; m_cnt = 0;
    if (with_strobe) begin
      exp_q.push_back(predict(0)); req_q.push_back(req); m_cnt = 1;
    end
    @(negedge clk);
    frame_sync = 1'b0;
    slot_strobe = 1'b0;
  endtask

  task automatic slots(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slot_strobe = 1'b1;
      exp_q.push_back(predict(m_cnt)); req_q.push_back(req);
      m_cnt++;
      @(negedge clk);
      slot_strobe = 1'b0;
    end
  endtask

  // strobe expected to be ignored: observe res_valid after it
  task automatic dead_slot(string req);
    @(negedge clk);
    slot_strobe = 1'b1;
    @(negedge clk);
    slot_strobe = 1'b0;
    check(req, res_valid == 1'b0, {31'd0, res_valid}, 32'd0);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8 * 200000);
    check("watchdog", 1'b0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid", res_valid == 1'b0, {31'd0, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", res_valid == 1'b0, {31'd0, res_valid}, 0);
    dead_slot("R7 strobe before first sync");

    // R1: selection off, bits random
    tx_en_bits = rnd128(); rx_en_bits = rnd128(); sel_mode = 2'b00; wide_sel = 1'b0;
    fsync(0, "R1"); slots(40, "R1 mode off");

    // R2 + R5: enable-select, 128 channels, full frame then an extra strobe
    sel_mode = 2'b01; wide_sel = 1'b1; tx_en_bits = rnd128();
    fsync(0, "R2"); slots(128, "R2/R5 enable-select wide");
    dead_slot("R7 strobe past channel 127");

    // R3 + R6: mask-select, two blocks at pair 1
    sel_mode = 2'b10; wide_sel = 1'b0; tx_pair = 2'd1; rx_pair = 2'd3; tx_en_bits = rnd128();
    fsync(0, "R3"); slots(128, "R3/R6 mask-select narrow");

    // R6: enable-select narrow, pair 3 at the top of the frame
    sel_mode = 2'b01; tx_pair = 2'd3; tx_en_bits = rnd128();
    fsync(0, "R6"); slots(128, "R6 enable-select pair 3");

    // R4 + R10: symmetric narrow, pointers differ
    sel_mode = 2'b11; tx_pair = 2'd0; rx_pair = 2'd2;
    tx_en_bits = rnd128(); rx_en_bits = rnd128();
    fsync(0, "R4"); slots(128, "R4/R10 symmetric narrow");

    // R4: symmetric wide
    wide_sel = 1'b1; tx_en_bits = rnd128(); rx_en_bits = rnd128();
    fsync(0, "R4"); slots(128, "R4 symmetric wide");

    // R9: mid-frame rewrite must not take effect
    sel_mode = 2'b01; tx_en_bits = rnd128();
    fsync(0, "R9"); slots(10, "R9 before rewrite");
    sel_mode = 2'b10; tx_en_bits = ~tx_en_bits; wide_sel = 1'b0;
    slots(30, "R9 after rewrite");

    // R8: sync and strobe together, new mode presented in that cycle
    sel_mode = 2'b11; wide_sel = 1'b1; rx_en_bits = rnd128(); tx_en_bits = rnd128();
    rx_en_bits[0] = 1'b1; tx_en_bits[0] = 1'b0;
    fsync(1, "R8 sync with strobe"); slots(20, "R8 continuation");

    repeat (4) @(negedge clk);
    check("R7 all results seen", exp_q.size() == 0, exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule